// File: doc/BRIEF.md
# Ethernet Source Address Inserter

This block sits in an Ethernet transmit path and edits each outgoing frame as it streams through, one byte per beat. For every frame it applies one of three edits. It can forward the frame untouched. It can splice a 6-byte source address in right after the destination address. It can overwrite the six bytes that already hold the source address. The address comes from one of two 48-bit station address inputs. Because an edit changes the frame contents, the block does not pass on any old check sequence. Input frames carry none, and the block appends a freshly computed CRC-32 frame check sequence to every frame.

A control word travels beside the data stream: a first-segment flag, a 2-bit edit mode and an address-select bit. The block captures the control word on the first byte of a frame, and only when that byte carries the first-segment flag. It keeps the captured value until the frame's last check byte has left. Both stream edges use valid/ready handshakes. The input is stalled while inserted address bytes and check bytes are being emitted, and back-pressure on the output passes straight through to the input.

Top module: `eth_sa_editor`

## Requirements
- R1: After reset, with no input offered and the output not ready, m_valid, m_last and s_ready are all low.
- R2: Mode 0 (cw_mode = 2'b00) forwards every input byte unchanged and in order, and the four check bytes follow.
- R3: Mode 3 (cw_mode = 2'b11) gives exactly the same output as mode 0.
- R4: Mode 1 (insert, cw_mode = 2'b01) forwards input bytes 0..5, then emits the six selected address bytes with s_ready low, then forwards the remaining input bytes, so the frame grows by 6. A frame shorter than 6 bytes gets no insertion. A frame of exactly 6 bytes gets the address after its sixth byte.
- R5: Mode 2 (replace, cw_mode = 2'b10) accepts input bytes 6..11 but outputs address bytes 0..5 in their place. The frame length stays the same, and a shorter frame has only the positions it reaches replaced.
- R6: cw_sel = 0 selects mac_a0 and cw_sel = 1 selects mac_a1. Bits [7:0] of the selected address are the first address byte on the wire, then [15:8], and so on.
- R7: The control word is taken only from the first byte of a frame, and only when cw_first is high there. A first byte with cw_first low gives mode 0 for that frame, and control values offered with later bytes of the frame have no effect.
- R8: Each output frame ends with four check bytes: the CRC-32 (reflected polynomial 0xEDB88320, start value all ones, final inversion) over every output byte before them, least significant byte first. m_last is high on the fourth check byte and on no other beat.
- R9: When m_valid is high and m_ready is low, m_data, m_last and m_valid hold until the transfer. s_ready is never high while m_ready is low. No byte is lost or repeated.
- R10: Back-to-back frames with no idle cycle between them are each edited according to their own control word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_data | input | 8 | Input frame byte |
| s_valid | input | 1 | Input byte valid |
| s_last | input | 1 | Input byte is the frame's last |
| s_ready | output | 1 | Block accepts the input byte |
| cw_first | input | 1 | Control word marks a frame's first segment |
| cw_mode | input | 2 | Edit mode: 00 keep, 01 insert, 10 replace, 11 treated as keep |
| cw_sel | input | 1 | Address select: 0 picks mac_a0, 1 picks mac_a1 |
| mac_a0 | input | 8*MAC_BYTES | Station address 0, bits [7:0] sent first |
| mac_a1 | input | 8*MAC_BYTES | Station address 1, bits [7:0] sent first |
| m_data | output | 8 | Output frame byte |
| m_valid | output | 1 | Output byte valid |
| m_last | output | 1 | Output byte is the last check byte |
| m_ready | input | 1 | Downstream accepts the output byte |

## Verification
Directed frames cover each mode with both address selects. They show whether the right register is used and whether the spliced or overwritten bytes land at positions 6 to 11. Short frames of 1, 3, 6 and 8 bytes separate the "no insertion before the destination address completes" rule from the exact-six case, and they show partial replacement. Frames without the first-segment flag, and frames with changing control values on later bytes, show whether the latch ignores them. A full-throughput back-to-back run followed by a long random run with random valid gaps and random output stalls separates per-frame mode capture from stall handling, and the CRC bytes expose any byte that was dropped or duplicated.

// File: rtl/sai_pkg.sv
package sai_pkg;
   typedef enum logic [1:0] {
      SA_KEEP    = 2'b00,
      SA_INSERT  = 2'b01,
      SA_REPLACE = 2'b10,
      SA_RSVD    = 2'b11
   } sa_mode_e;

   typedef enum logic [1:0] {
      PH_BODY = 2'b00,
      PH_ADDR = 2'b01,
      PH_FCS  = 2'b10
   } sa_phase_e;
endpackage

// File: rtl/sai_crc32.sv
// One-byte update of a reflected CRC-32, unrolled bit by bit.
module sai_crc32 #(
   parameter logic [31:0] POLY = 32'hEDB88320
) (
   input  logic [31:0] crc_in,
   input  logic [7:0]  byte_in,
   output logic [31:0] crc_out
);
   logic [31:0] stage [9];

   assign stage[0] = crc_in ^ {24'h0, byte_in};

   for (genvar b = 0; b < 8; b++) begin : g_bit
      assign stage[b+1] = stage[b][0] ? ((stage[b] >> 1) ^ POLY) : (stage[b] >> 1);
   end

   assign crc_out = stage[8];
endmodule

// File: rtl/sai_addr_pick.sv
// Selects one byte of one of two station addresses.
module sai_addr_pick #(
   parameter int MAC_BYTES = 6,
   localparam int AI_W     = $clog2(MAC_BYTES)
) (
   input  logic [8*MAC_BYTES-1:0] addr0,
   input  logic [8*MAC_BYTES-1:0] addr1,
   input  logic                   sel,
   input  logic [AI_W-1:0]        idx,
   output logic [7:0]             byte_out
);
   logic [8*MAC_BYTES-1:0] chosen;

   assign chosen = sel ? addr1 : addr0;

   always_comb begin
      byte_out = 8'h00;
      for (int k = 0; k < MAC_BYTES; k++) begin
         if (idx == AI_W'(k)) byte_out = chosen[8*k +: 8];
      end
   end
endmodule

// File: rtl/sai_ctrl.sv
// Frame sequencer: body bytes, spliced address bytes, check bytes.
module sai_ctrl
   import sai_pkg::*;
#(
   parameter int MAC_BYTES = 6,
   parameter int FCS_BYTES = 4,
   localparam int AI_W     = $clog2(MAC_BYTES),
   localparam int FI_W     = $clog2(FCS_BYTES),
   localparam int CNT_W    = $clog2(2*MAC_BYTES + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            s_valid,
   input  logic            s_last,
   input  logic            m_ready,
   input  logic            cw_first,
   input  logic [1:0]      cw_mode,
   input  logic            cw_sel,
   output logic            s_ready,
   output logic            m_valid,
   output logic            m_last,
   output logic            beat,
   output sa_phase_e       phase,
   output logic            use_addr,
   output logic            addr_sel,
   output logic [AI_W-1:0] addr_idx,
   output logic [FI_W-1:0] fcs_idx
);
   sa_phase_e         ph_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [AI_W-1:0]   aidx_q;
   logic [FI_W-1:0]   fidx_q;
   sa_mode_e          lmode_q;
   logic              lsel_q;
   logic              pend_q;

   logic              at_start;
   sa_mode_e          cur_mode;
   logic              cur_sel;
   logic              repl_win;
   logic [CNT_W-1:0]  rel_pos;

   assign at_start = (ph_q == PH_BODY) && (cnt_q == '0);
   assign cur_mode = at_start ? (cw_first ? sa_mode_e'(cw_mode) : SA_KEEP) : lmode_q;
   assign cur_sel  = at_start ? cw_sel : lsel_q;
   assign repl_win = (cur_mode == SA_REPLACE) && (cnt_q >= CNT_W'(MAC_BYTES))
                     && (cnt_q < CNT_W'(2*MAC_BYTES));
   assign rel_pos  = cnt_q - CNT_W'(MAC_BYTES);

   always_comb begin
      s_ready = 1'b0;
      m_valid = 1'b0;
      m_last  = 1'b0;
      unique case (ph_q)
         PH_BODY: begin
            m_valid = s_valid;
            s_ready = m_ready;
         end
         PH_ADDR: m_valid = 1'b1;
         default: begin
            m_valid = 1'b1;
            m_last  = (fidx_q == FI_W'(FCS_BYTES-1));
         end
      endcase
   end

   assign beat     = m_valid && m_ready;
   assign phase    = ph_q;
   assign use_addr = (ph_q == PH_ADDR) || ((ph_q == PH_BODY) && repl_win);
   assign addr_sel = cur_sel;
   assign addr_idx = (ph_q == PH_ADDR) ? aidx_q : rel_pos[AI_W-1:0];
   assign fcs_idx  = fidx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q    <= PH_BODY;
         cnt_q   <= '0;
         aidx_q  <= '0;
         fidx_q  <= '0;
         lmode_q <= SA_KEEP;
         lsel_q  <= 1'b0;
         pend_q  <= 1'b0;
      end else if (beat) begin
         unique case (ph_q)
            PH_BODY: begin
               if (at_start) begin
                  lmode_q <= cur_mode;
                  lsel_q  <= cur_sel;
               end
               if (cnt_q < CNT_W'(2*MAC_BYTES)) cnt_q <= cnt_q + 1'b1;
               if ((cur_mode == SA_INSERT) && (cnt_q == CNT_W'(MAC_BYTES-1))) begin
                  ph_q   <= PH_ADDR;
                  aidx_q <= '0;
                  pend_q <= s_last;
               end else if (s_last) begin
                  ph_q   <= PH_FCS;
                  fidx_q <= '0;
               end
            end
            PH_ADDR: begin
               aidx_q <= aidx_q + 1'b1;
               if (aidx_q == AI_W'(MAC_BYTES-1)) begin
                  ph_q   <= pend_q ? PH_FCS : PH_BODY;
                  fidx_q <= '0;
               end
            end
            default: begin
               fidx_q <= fidx_q + 1'b1;
               if (fidx_q == FI_W'(FCS_BYTES-1)) begin
                  ph_q  <= PH_BODY;
                  cnt_q <= '0;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/eth_sa_editor.sv
// Streaming source address insert/replace stage with check sequence append.
module eth_sa_editor
   import sai_pkg::*;
#(
   parameter int          MAC_BYTES = 6,
   parameter int          FCS_BYTES = 4,
   parameter logic [31:0] CRC_POLY  = 32'hEDB88320,
   localparam int         AI_W      = $clog2(MAC_BYTES),
   localparam int         FI_W      = $clog2(FCS_BYTES)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [7:0]             s_data,
   input  logic                   s_valid,
   input  logic                   s_last,
   output logic                   s_ready,
   input  logic                   cw_first,
   input  logic [1:0]             cw_mode,
   input  logic                   cw_sel,
   input  logic [8*MAC_BYTES-1:0] mac_a0,
   input  logic [8*MAC_BYTES-1:0] mac_a1,
   output logic [7:0]             m_data,
   output logic                   m_valid,
   output logic                   m_last,
   input  logic                   m_ready
);
   if (MAC_BYTES < 2) begin : g_bad_mac
      $error("MAC_BYTES must be at least 2");
   end
   if (FCS_BYTES != 4) begin : g_bad_fcs
      $error("FCS_BYTES must be 4 for a CRC-32 check sequence");
   end

   logic            beat;
   sa_phase_e       phase;
   logic            use_addr;
   logic            addr_sel;
   logic [AI_W-1:0] addr_idx;
   logic [FI_W-1:0] fcs_idx;
   logic [7:0]      addr_byte;
   logic [31:0]     crc_q;
   logic [31:0]     crc_next;
   logic [7:0]      fcs_byte;

   sai_ctrl #(
      .MAC_BYTES(MAC_BYTES),
      .FCS_BYTES(FCS_BYTES)
   ) ctrl_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .s_valid  (s_valid),
      .s_last   (s_last),
      .m_ready  (m_ready),
      .cw_first (cw_first),
      .cw_mode  (cw_mode),
      .cw_sel   (cw_sel),
      .s_ready  (s_ready),
      .m_valid  (m_valid),
      .m_last   (m_last),
      .beat     (beat),
      .phase    (phase),
      .use_addr (use_addr),
      .addr_sel (addr_sel),
      .addr_idx (addr_idx),
      .fcs_idx  (fcs_idx)
   );

   sai_addr_pick #(.MAC_BYTES(MAC_BYTES)) pick_i (
      .addr0    (mac_a0),
      .addr1    (mac_a1),
      .sel      (addr_sel),
      .idx      (addr_idx),
      .byte_out (addr_byte)
   );

   sai_crc32 #(.POLY(CRC_POLY)) crc_i (
      .crc_in  (crc_q),
      .byte_in (m_data),
      .crc_out (crc_next)
   );

   assign fcs_byte = ~crc_q[{fcs_idx, 3'b000} +: 8];

   always_comb begin
      if (phase == PH_FCS) m_data = fcs_byte;
      else if (use_addr)   m_data = addr_byte;
      else                 m_data = s_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_q <= '1;
      end else if (beat) begin
         if (phase != PH_FCS) crc_q <= crc_next;
         else if (m_last)     crc_q <= '1;
      end
   end
endmodule

// File: rtl/sai_chk.sv
// Protocol checker, attached to every instance of the top module.
module sai_chk #(
   parameter int FCS_BYTES = 4
) (
   input logic       clk,
   input logic       rst_n,
   input logic       s_valid,
   input logic       s_ready,
   input logic [7:0] m_data,
   input logic       m_valid,
   input logic       m_last,
   input logic       m_ready
);
   logic [15:0] beats_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) beats_q <= '0;
      else if (m_valid && m_ready) beats_q <= m_last ? '0 : ((beats_q == 16'hFFFF) ? beats_q : beats_q + 1'b1);
   end

   // R9
   in_needs_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s_valid && s_ready) |-> (m_valid && m_ready));

   // R9
   no_ready_leak_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !m_ready |-> !s_ready);

   // R9
   hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));

   // R8
   last_is_fcs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_last |-> (m_valid && !s_ready));

   // R8
   fcs_tail_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && m_ready && m_last) |-> (beats_q >= 16'(FCS_BYTES)));
endmodule

bind eth_sa_editor sai_chk #(.FCS_BYTES(FCS_BYTES)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .s_valid (s_valid),
   .s_ready (s_ready),
   .m_data  (m_data),
   .m_valid (m_valid),
   .m_last  (m_last),
   .m_ready (m_ready)
);

// File: tb/eth_sa_editor_tb_top.sv
`timescale 1ns/1ps
module eth_sa_editor_tb_top;
   localparam int WD_LIMIT = 150000;

   typedef struct packed {
      logic [7:0] d;
      logic       last;
      logic       first;
      logic [1:0] mode;
      logic       sel;
   } ibeat_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  s_data = '0;
   logic        s_valid = 1'b0;
   logic        s_last = 1'b0;
   logic        s_ready;
   logic        cw_first = 1'b0;
   logic [1:0]  cw_mode = '0;
   logic        cw_sel = 1'b0;
   logic [47:0] mac_a0 = 48'h5A4B3C2D1E0F;
   logic [47:0] mac_a1 = 48'hC1B2A3948576;
   logic [7:0]  m_data;
   logic        m_valid;
   logic        m_last;
   logic        m_ready = 1'b0;

   always #2.5 clk = ~clk;

   eth_sa_editor dut_i (
      .clk(clk), .rst_n(rst_n),
      .s_data(s_data), .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
      .cw_first(cw_first), .cw_mode(cw_mode), .cw_sel(cw_sel),
      .mac_a0(mac_a0), .mac_a1(mac_a1),
      .m_data(m_data), .m_valid(m_valid), .m_last(m_last), .m_ready(m_ready)
   );

   int     n_chk = 0;
   int     n_bad = 0;
   int     cycles = 0;
   bit     burst = 1'b0;
   ibeat_t in_q[$];
   logic [8:0] exp_q[$];
   string  tag_q[$];

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] addr_byte(input bit sel, input int k);
      return sel ? mac_a1[8*k +: 8] : mac_a0[8*k +: 8];
   endfunction

   function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
      logic [31:0] r = c ^ {24'h0, b};
      for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
      return r;
   endfunction

   task automatic add_frame(input int len, input int mode, input bit sel,
                            input bit first, input bit garble, input string extra);
      logic [7:0] outb[$];
      logic [31:0] c = 32'hFFFFFFFF;
      int em = first ? mode : 0;
      string tag;
      if (em == 1)      tag = "R4";
      else if (em == 2) tag = "R5";
      else if (first && mode == 3) tag = "R3";
      else              tag = "R2";
      tag = {tag, " R6"};
      if (!first || garble) tag = {tag, " R7"};
      tag = {tag, extra};
      for (int i = 0; i < len; i++) begin
         ibeat_t bt;
         logic [7:0] ob;
         bt.d    = 8'($urandom);
         bt.last = (i == len - 1);
         if (i == 0) begin
            bt.first = first; bt.mode = 2'(mode); bt.sel = sel;
         end else if (garble) begin
            bt.first = 1'($urandom); bt.mode = 2'($urandom); bt.sel = 1'($urandom);
         end else begin
            bt.first = 1'b0; bt.mode = 2'b00; bt.sel = 1'b0;
         end
         in_q.push_back(bt);
         ob = bt.d;
         if (em == 2 && i >= 6 && i < 12) ob = addr_byte(sel, i - 6);
         outb.push_back(ob);
         if (em == 1 && i == 5)
            for (int k = 0; k < 6; k++) outb.push_back(addr_byte(sel, k));
      end
      foreach (outb[i]) begin
         c = crc_step(c, outb[i]);
         exp_q.push_back({1'b0, outb[i]});
         tag_q.push_back(tag);
      end
      c = ~c;
      for (int k = 0; k < 4; k++) begin
         exp_q.push_back({(k == 3), c[8*k +: 8]});
         tag_q.push_back({"R8", extra});
      end
   endtask

   task automatic run_traffic();
      bit in_fire = 1'b0;
      bit prev_stall = 1'b0;
      logic [7:0] st_d = '0;
      logic st_l = 1'b0;
      while ((exp_q.size() != 0 || in_q.size() != 0) && cycles < WD_LIMIT) begin
         @(negedge clk);
         cycles++;
         if (s_valid && in_fire) begin
            void'(in_q.pop_front());
            s_valid = 1'b0;
         end
         if (!s_valid && in_q.size() > 0 && (burst || $urandom_range(3) != 0)) begin
            s_data   = in_q[0].d;
            s_last   = in_q[0].last;
            cw_first = in_q[0].first;
            cw_mode  = in_q[0].mode;
            cw_sel   = in_q[0].sel;
            s_valid  = 1'b1;
         end
         m_ready = burst ? 1'b1 : ($urandom_range(2) != 0);
         #1;
         if (prev_stall)
            check(m_valid && m_data == st_d && m_last == st_l, "R9", "held output",
                  {23'h0, m_valid, m_data}, {23'h1, 1'b1, st_d});
         if (!m_ready)
            check(!s_ready, "R9", "s_ready while stalled", 32'(s_ready), 32'h0);
         if (m_valid && m_ready) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R9", "unexpected output byte", 32'(m_data), 32'h0);
            end else begin
               logic [8:0] e = exp_q.pop_front();
               string t = tag_q.pop_front();
               check(m_data == e[7:0] && m_last == e[8], t, "data/last",
                     {23'h0, m_last, m_data}, {23'h0, e});
            end
         end
         in_fire    = s_valid && s_ready;
         prev_stall = m_valid && !m_ready;
         st_d       = m_data;
         st_l       = m_last;
      end
   endtask

   initial begin
      void'($urandom(32'd24681357));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      // R1: idle after reset
      check(!m_valid && !m_last && !s_ready, "R1", "idle state",
            {29'h0, m_valid, m_last, s_ready}, 32'h0);

      // Directed frames at full throughput, back to back (R10)
      burst = 1'b1;
      add_frame(20, 0, 1'b0, 1'b1, 1'b0, " R10");
      add_frame(15, 3, 1'b1, 1'b1, 1'b0, " R10");
      add_frame(30, 1, 1'b1, 1'b1, 1'b0, " R10");
      add_frame(30, 2, 1'b0, 1'b1, 1'b0, " R10");
      add_frame(20, 1, 1'b1, 1'b0, 1'b0, " R10");
      add_frame(25, 2, 1'b1, 1'b1, 1'b1, " R10");
      add_frame(18, 1, 1'b0, 1'b1, 1'b1, " R10");
      run_traffic();

      // Directed short frames under random stalls
      burst = 1'b0;
      add_frame(3, 1, 1'b0, 1'b1, 1'b0, "");
      add_frame(6, 1, 1'b1, 1'b1, 1'b0, "");
      add_frame(8, 2, 1'b1, 1'b1, 1'b0, "");
      add_frame(1, 2, 1'b0, 1'b1, 1'b0, "");
      add_frame(1, 1, 1'b1, 1'b1, 1'b0, "");
      add_frame(12, 2, 1'b0, 1'b1, 1'b0, "");
      add_frame(7, 1, 1'b0, 1'b1, 1'b0, "");
      add_frame(64, 0, 1'b1, 1'b1, 1'b1, "");
      run_traffic();

      // Constrained random frames
      for (int f = 0; f < 60; f++)
         add_frame($urandom_range(40, 1), $urandom_range(3), 1'($urandom),
                   ($urandom_range(7) != 0), 1'($urandom), "");
      run_traffic();

      if (cycles >= WD_LIMIT) begin
         n_chk++;
         n_bad++;
         $display("FAIL R9 watchdog expired actual=%0d expected<%0d", cycles, WD_LIMIT);
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end
endmodule